// File: doc/BRIEF.md
# HDB3 / AMI Bipolar Transmit Encoder

This block turns a unipolar NRZ bit stream, one bit per transmit clock, into a pair of rail bits (positive pulse, negative pulse) for a bipolar line driver. Marks alternate in polarity and spaces put no pulse on either rail. When zero substitution is enabled, every run of four zeros is replaced by a code that carries a deliberate bipolar violation. The substitution takes the form `000V` or `B00V`, chosen so that successive violations alternate in polarity and the line keeps no DC offset. A four-bit look-ahead pipeline lets the encoder rewrite a zero run before its first bit leaves, so the single-rail path has a fixed latency.

Three further sources can feed the line rails. A dual-rail bypass takes external positive and negative rail data, optionally active-low, and passes it straight through. A remote loopback copies recovered receive rails onto the transmit rails. An alarm indication mode sends a bipolar all-ones pattern clocked from a separate alarm clock. It overrides every other source, including the loopback.

Top module: `bipolar_tx_encoder`

## Requirements
- R1: While `rst_n` is low and after its release, until the first mark reaches the output, both `tx_p` and `tx_n` are 0. The first mark encoded after reset is a positive pulse (`tx_p`=1, `tx_n`=0).
- R2: In single-rail mode (`dual_rail`=0, `loop_en`=0, `ais_en`=0) with `hdb3_en`=0, the bit sampled on `nrz_in` at clock edge k is shown on the rails after edge k+4. A 1 is a single-rail pulse whose polarity is the opposite of the previous pulse. A 0 is `tx_p`=`tx_n`=0, and no zero run is ever substituted.
- R3: With `hdb3_en`=1 in single-rail mode, the same four-cycle latency holds. Each run of four consecutive zeros is replaced, scanning in time order, by a substitution code, so the output never carries four consecutive empty bit periods inside one enabled run. A reset leaves three zeros already counted toward the first window.
- R4: The substitution is `000V` when an odd number of non-violation pulses has been sent since the last violation, and `B00V` when that number is even. Reset starts the count as odd, so a zero run with no mark before it gives `000V`.
- R5: V is a pulse of the same polarity as the pulse sent just before it. B is a pulse of the opposite polarity to the previous pulse, as an ordinary mark would be.
- R6: With `dual_rail`=1 (and `loop_en`=0, `ais_en`=0), `tx_p`/`tx_n` show the values of `p_in`/`n_in` sampled at the previous clock edge. `hdb3_en` and `nrz_in` have no effect on the rails.
- R7: In dual-rail mode with `active_low`=1, the rail inputs are active-low: `tx_p` = NOT `p_in` and `tx_n` = NOT `n_in`, one clock later.
- R8: With `loop_en`=1 and `ais_en`=0, `tx_p`/`tx_n` show `rx_p`/`rx_n` sampled at the previous clock edge, whatever `dual_rail` is.
- R9: With `ais_en`=1, exactly one rail is high, and the high rail swaps on every rising edge of `ais_clk`. This takes effect without a clock edge and overrides loopback, dual-rail and encoder data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ais_clk | input | 1 | Alarm clock that paces the all-ones pattern |
| nrz_in | input | 1 | Unipolar NRZ transmit data |
| hdb3_en | input | 1 | 1 enables four-zero substitution |
| dual_rail | input | 1 | 1 selects the external rail bypass |
| active_low | input | 1 | 1 makes `p_in`/`n_in` active-low |
| p_in | input | 1 | External positive-rail data |
| n_in | input | 1 | External negative-rail data |
| loop_en | input | 1 | 1 sources the rails from recovered receive data |
| rx_p | input | 1 | Recovered receive positive rail |
| rx_n | input | 1 | Recovered receive negative rail |
| ais_en | input | 1 | 1 sends the all-ones alarm pattern |
| tx_p | output | 1 | Positive rail to the line driver |
| tx_n | output | 1 | Negative rail to the line driver |

## Verification
The bench builds the block with the default four-bit zero window. At that size an exhaustive sweep of every 10-bit input pattern, in both AMI and HDB3 mode, is cheap. It covers runs of up to ten zeros, back-to-back substitutions, both `000V` and `B00V` at every parity reachable from reset, and zero runs that merge with the zeros left in the pipeline by reset. Each expected rail pair comes from a scan written in the bench that counts pulses since the last violation. The rail-source modes are swept over every input combination and both polarities.

// File: rtl/bptx_pkg.sv
`timescale 1ns/1ps
package bptx_pkg;

  // Symbol held in one look-ahead slot.
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,   // plain space, still eligible for substitution
    SYM_MARK = 2'd1,   // ordinary mark
    SYM_LEAD = 2'd2,   // first slot of a substitution: B or 0
    SYM_VIOL = 2'd3    // last slot of a substitution: V
  } sym_t;

  typedef struct packed {
    logic p;
    logic n;
  } rails_t;

  // A single pulse of the given polarity (1 = positive).
  function automatic rails_t pulse(input logic positive);
    rails_t r;
    r.p = positive;
    r.n = ~positive;
    return r;
  endfunction

  // The lead slot carries a B pulse only when an even number of
  // ordinary pulses went out since the last violation.
  function automatic logic lead_sends_b(input logic odd_pulses);
    return ~odd_pulses;
  endfunction

endpackage

// File: rtl/bptx_lookahead.sv
`timescale 1ns/1ps
module bptx_lookahead
  import bptx_pkg::*;
#(
  parameter int ZRUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hdb3_en,
  input  logic bit_in,
  output sym_t head,
  output logic subst_fire
);

  localparam int LAST = ZRUN - 1;

  sym_t pipe [ZRUN];
  logic window_clear;

  // The window is the incoming bit plus the ZRUN-1 youngest slots.
  always_comb begin
    window_clear = ~bit_in;
    for (int i = 0; i < LAST; i++) begin
      if (pipe[i] != SYM_ZERO) window_clear = 1'b0;
    end
  end

  assign subst_fire = hdb3_en & window_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ZRUN; i++) pipe[i] <= SYM_ZERO;
    end else begin
      pipe[0] <= subst_fire ? SYM_VIOL : (bit_in ? SYM_MARK : SYM_ZERO);
      for (int i = 1; i < ZRUN; i++) begin
        pipe[i] <= (subst_fire && i == LAST) ? SYM_LEAD : pipe[i-1];
      end
    end
  end

  assign head = pipe[LAST];

endmodule

// File: rtl/bptx_polarity.sv
`timescale 1ns/1ps
module bptx_polarity
  import bptx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sym_t   head,
  output rails_t rails,
  output logic   emit_v,
  output logic   emit_b
);

  logic last_pos, odd_pulses;
  logic nxt_last, nxt_odd;

  always_comb begin
    rails    = '0;
    nxt_last = last_pos;
    nxt_odd  = odd_pulses;
    emit_v   = 1'b0;
    emit_b   = 1'b0;
    unique case (head)
      SYM_MARK: begin
        rails    = pulse(~last_pos);
        nxt_last = ~last_pos;
        nxt_odd  = ~odd_pulses;
      end
      SYM_LEAD: begin
        if (lead_sends_b(odd_pulses)) begin
          emit_b   = 1'b1;
          rails    = pulse(~last_pos);
          nxt_last = ~last_pos;
          nxt_odd  = 1'b1;
        end
      end
      SYM_VIOL: begin
        emit_v  = 1'b1;
        rails   = pulse(last_pos);
        nxt_odd = 1'b0;
      end
      default: ;
    endcase
  end

  // Reset: last pulse negative, odd count so the first code is 000V.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos   <= 1'b0;
      odd_pulses <= 1'b1;
    end else begin
      last_pos   <= nxt_last;
      odd_pulses <= nxt_odd;
    end
  end

endmodule

// File: rtl/bptx_ais_gen.sv
`timescale 1ns/1ps
module bptx_ais_gen
  import bptx_pkg::*;
(
  input  logic   ais_clk,
  input  logic   rst_n,
  output rails_t rails
);

  logic phase;

  always_ff @(posedge ais_clk or negedge rst_n) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  assign rails = pulse(phase);

endmodule

// File: rtl/bipolar_tx_encoder.sv
`timescale 1ns/1ps
module bipolar_tx_encoder
  import bptx_pkg::*;
#(
  parameter int ZRUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ais_clk,
  input  logic nrz_in,
  input  logic hdb3_en,
  input  logic dual_rail,
  input  logic active_low,
  input  logic p_in,
  input  logic n_in,
  input  logic loop_en,
  input  logic rx_p,
  input  logic rx_n,
  input  logic ais_en,
  output logic tx_p,
  output logic tx_n
);

  sym_t   head;
  rails_t enc_rails, ais_rails, ext_rails, loop_rails, sel_rails, line_q;

  // Named internal events for the checker.
  logic subst_fire_w, emit_v_w, emit_b_w, enc_p_w, enc_n_w;

  bptx_lookahead #(.ZRUN(ZRUN)) u_look (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdb3_en    (hdb3_en),
    .bit_in     (nrz_in),
    .head       (head),
    .subst_fire (subst_fire_w)
  );

  bptx_polarity u_pol (
    .clk    (clk),
    .rst_n  (rst_n),
    .head   (head),
    .rails  (enc_rails),
    .emit_v (emit_v_w),
    .emit_b (emit_b_w)
  );

  bptx_ais_gen u_ais (
    .ais_clk (ais_clk),
    .rst_n   (rst_n),
    .rails   (ais_rails)
  );

  assign enc_p_w = enc_rails.p;
  assign enc_n_w = enc_rails.n;

  assign ext_rails.p  = p_in ^ active_low;
  assign ext_rails.n  = n_in ^ active_low;
  assign loop_rails.p = rx_p;
  assign loop_rails.n = rx_n;

  always_comb begin
    if (loop_en)        sel_rails = loop_rails;
    else if (dual_rail) sel_rails = ext_rails;
    else                sel_rails = enc_rails;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= sel_rails;
  end

  // Alarm pattern overrides every other source at the pins.
  assign tx_p = ais_en ? ais_rails.p : line_q.p;
  assign tx_n = ais_en ? ais_rails.n : line_q.n;

endmodule

// File: rtl/bptx_checker.sv
`timescale 1ns/1ps
module bptx_checker (
  input logic clk,
  input logic ais_clk,
  input logic rst_n,
  input logic ais_en,
  input logic loop_en,
  input logic dual_rail,
  input logic active_low,
  input logic p_in,
  input logic n_in,
  input logic rx_p,
  input logic rx_n,
  input logic tx_p,
  input logic tx_n,
  input logic enc_p,
  input logic enc_n,
  input logic emit_v
);

  logic armed, ais_armed, chk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_ff @(posedge ais_clk or negedge rst_n) begin
    if (!rst_n) ais_armed <= 1'b0;
    else        ais_armed <= 1'b1;
  end

  // Independent record of the polarity of the last encoder pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             chk_last <= 1'b0;
    else if (enc_p | enc_n) chk_last <= enc_p;
  end

  assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((enc_p | enc_n) && !emit_v) |-> (enc_p == !chk_last));

  assert_viol_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    emit_v |-> ((enc_p != enc_n) && (enc_p == chk_last)));

  assert_dual_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ais_en && !$past(loop_en) && $past(dual_rail)) |->
      (tx_p == ($past(p_in) ^ $past(active_low)) &&
       tx_n == ($past(n_in) ^ $past(active_low))));

  assert_loop_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ais_en && $past(loop_en)) |->
      (tx_p == $past(rx_p) && tx_n == $past(rx_n)));

  assert_ais_one_rail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ais_en |-> (tx_p != tx_n));

  assert_ais_toggle_R9: assert property (@(posedge ais_clk) disable iff (!rst_n)
    (ais_armed && ais_en && $past(ais_en)) |-> (tx_p != $past(tx_p)));

endmodule

bind bipolar_tx_encoder bptx_checker u_chk (
  .clk        (clk),
  .ais_clk    (ais_clk),
  .rst_n      (rst_n),
  .ais_en     (ais_en),
  .loop_en    (loop_en),
  .dual_rail  (dual_rail),
  .active_low (active_low),
  .p_in       (p_in),
  .n_in       (n_in),
  .rx_p       (rx_p),
  .rx_n       (rx_n),
  .tx_p       (tx_p),
  .tx_n       (tx_n),
  .enc_p      (enc_p_w),
  .enc_n      (enc_n_w),
  .emit_v     (emit_v_w)
);

// File: tb/bipolar_tx_encoder_tb.sv
`timescale 1ns/1ps
module bipolar_tx_encoder_tb;

  logic clk = 1'b0;
  logic rst_n, nrz_in, hdb3_en, dual_rail, active_low, p_in, n_in;
  logic loop_en, rx_p, rx_n, ais_en;
  logic tx_p, tx_n;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  bipolar_tx_encoder u_dut (
    .clk (clk), .rst_n (rst_n), .ais_clk (clk),
    .nrz_in (nrz_in), .hdb3_en (hdb3_en),
    .dual_rail (dual_rail), .active_low (active_low),
    .p_in (p_in), .n_in (n_in),
    .loop_en (loop_en), .rx_p (rx_p), .rx_n (rx_n),
    .ais_en (ais_en), .tx_p (tx_p), .tx_n (tx_n)
  );

  // Model stream: three zeros left by reset, then the data, then padding.
  logic mbits [64];
  logic exp_p [64];
  logic exp_n [64];

  task automatic check(input string req, input logic [1:0] act,
                       input logic [1:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  // Expected rails from the requirement text: alternate marks, scan zero
  // runs in time order, pick the code from the pulse-count parity.
  task automatic build_model(input int mlen, input logic hdb);
    logic last = 1'b0;
    logic odd  = 1'b1;
    int i = 0;
    for (int k = 0; k < mlen; k++) begin exp_p[k] = 0; exp_n[k] = 0; end
    while (i < mlen) begin
      if (hdb && i + 3 < mlen &&
          !(mbits[i] | mbits[i+1] | mbits[i+2] | mbits[i+3])) begin
        if (!odd) begin
          last = ~last; exp_p[i] = last; exp_n[i] = ~last; odd = 1'b1;
        end
        exp_p[i+3] = last; exp_n[i+3] = ~last; odd = 1'b0;
        i += 4;
      end else begin
        if (mbits[i]) begin
          last = ~last; exp_p[i] = last; exp_n[i] = ~last; odd = ~odd;
        end
        i++;
      end
    end
  endtask

  task automatic do_reset(input logic hdb, input logic dual, input logic loop);
    rst_n = 1'b0; nrz_in = 0; hdb3_en = hdb; dual_rail = dual;
    active_low = 0; p_in = 0; n_in = 0; loop_en = loop;
    rx_p = 0; rx_n = 0; ais_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_seq(input logic [9:0] pat, input int len,
                         input logic hdb, input string tag);
    int mlen = 3 + len + 4;
    for (int k = 0; k < mlen; k++) mbits[k] = 1'b0;
    for (int j = 0; j < len; j++) mbits[3 + j] = pat[j];
    build_model(mlen, hdb);
    do_reset(hdb, 1'b0, 1'b0);
    for (int e = 1; e <= len + 4; e++) begin
      nrz_in = (e <= len) ? pat[e-1] : 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (e >= 5)
        check(tag, {tx_p, tx_n}, {exp_p[e-2], exp_n[e-2]},
              $sformatf("pattern %b hdb3=%0b bit %0d", pat, hdb, e - 4));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic prev;
    // R1: rails low in reset and right after release.
    do_reset(1'b1, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1", {tx_p, tx_n}, 2'b00, "rails during reset");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", {tx_p, tx_n}, 2'b00, "rails after release");

    // R1: first mark positive; R4: code choice right after reset.
    run_seq(10'b0000000001, 6, 1'b0, "R1");
    run_seq(10'b0000000001, 6, 1'b1, "R4");   // mark then zeros: B00V
    run_seq(10'b0000000011, 8, 1'b1, "R4");   // two marks then zeros: 000V
    run_seq(10'b0000000000, 8, 1'b1, "R4");   // zeros only: 000V first

    // R2 / R3 / R4 / R5: every 10-bit pattern in both coding modes.
    for (int pat = 0; pat < 1024; pat++) begin
      run_seq(pat[9:0], 10, 1'b0, "R2");
      run_seq(pat[9:0], 10, 1'b1, "R3 R4 R5");
    end

    // R6 / R7: dual-rail bypass, HDB3 enabled and zero data ignored.
    do_reset(1'b1, 1'b1, 1'b0);
    for (int al = 0; al < 2; al++) begin
      for (int c = 0; c < 12; c++) begin
        active_low = al[0]; p_in = c[1]; n_in = c[0]; nrz_in = 1'b0;
        @(posedge clk); @(negedge clk);
        check(al ? "R7" : "R6", {tx_p, tx_n},
              {c[1] ^ al[0], c[0] ^ al[0]},
              $sformatf("dual rail p=%0b n=%0b al=%0d", c[1], c[0], al));
      end
    end

    // R8: loopback wins over dual-rail and encoder data.
    for (int d = 0; d < 2; d++) begin
      do_reset(1'b1, d[0], 1'b1);
      for (int c = 0; c < 8; c++) begin
        rx_p = c[1]; rx_n = c[0]; p_in = ~c[1]; n_in = ~c[0]; nrz_in = c[2];
        @(posedge clk); @(negedge clk);
        check("R8", {tx_p, tx_n}, {c[1], c[0]},
              $sformatf("loopback rx=%0b%0b dual=%0d", c[1], c[0], d));
      end
    end

    // R9: alarm pattern overrides loopback at once and alternates.
    rx_p = 1'b1; rx_n = 1'b0;
    @(posedge clk); @(negedge clk);
    ais_en = 1'b1;
    #1;
    check("R9", {1'b0, tx_p ^ tx_n}, 2'b01, "alarm one rail immediately");
    prev = tx_p;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      check("R9", {tx_p ^ tx_n, tx_p}, {1'b1, ~prev}, "alarm alternation");
      prev = tx_p;
    end
    ais_en = 1'b0;
    #1;
    check("R9", {tx_p, tx_n}, 2'b10, "loopback data back after alarm");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule